// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Scheduling

This block is an on-chip scratchpad split into 32 word-wide banks, serving one wavefront-wide request at a time. A request carries an opcode, one byte address per lane, one data word per lane and a lane-active mask. The block finds the active lanes that collide in a bank and spreads the access over as many single-cycle passes as needed, so that no bank is touched at two addresses in one pass. Lanes that read the same word share one bank read. Lanes that write the same word are merged in one pass, and the highest-numbered lane's value is kept. Atomic adds to a shared word are applied one lane per pass.

Read results are gathered for the whole wavefront. They then leave over a return port that is 16 lanes wide, one beat per cycle. A one-cycle done pulse ends every operation. `cyclesUsed` reports the number of passes the operation needed, so anything above one is the cost of conflicts. `busy` holds off new requests until the done pulse.

Top module: `banked_scratch`

## Requirements
- R1: Opcode 0 reads, 1 writes, 2 atomically adds lane data to the addressed word. A byte address selects bank bits [6:2] and row bits [ADDR_W-1:7]; bits [1:0] are ignored. Every word reads as zero after reset, and a read returns the last value written or added.
- R2: For reads and writes, the number of passes equals the largest, over all banks, count of distinct word addresses among the active lanes mapping to that bank.
- R3: Active lanes reading the same word are served in the same pass and all receive that word; they add no pass.
- R4: When several active lanes write the same word in one request, the word ends up holding the data of the highest-numbered of those lanes, and the merge takes one pass.
- R5: An atomic add serves one lane per bank per pass. Its pass count is the largest per-bank count of active lanes, and each word ends at its old value plus the sum of all active lanes' data aimed at it.
- R6: Inactive lanes change no memory word, and their read data is returned as zero.
- R7: Read data leaves in 4 consecutive beats (LANES/16), one per cycle, starting the cycle after the last pass. `rValid` is high during each beat. `rBeat` counts beats 0 to 3. Beat b carries lanes 16b to 16b+15, with lane 16b+j at `rData` bits [32j+31:32j].
- R8: `done` is high for exactly one cycle. Counting the cycle after the accepting clock edge as cycle 0, it rises in cycle P for writes and adds and in cycle P+4 for reads, where P is the pass count. `cyclesUsed` equals P while `done` is high.
- R9: `busy` is low after reset and high from the cycle after acceptance through the done cycle. Requests presented while busy is high are ignored.
- R10: A request with an all-zero mask completes with `done` in cycle 0, `cyclesUsed` of 0, no read beats and no memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present; taken when busy is low |
| reqOp | input | 2 | 0 read, 1 write, 2 atomic add, 3 treated as read |
| reqAddr | input | LANES*ADDR_W | Byte address per lane, lane i at [i*ADDR_W +: ADDR_W] |
| reqWdata | input | LANES*32 | Data word per lane, lane i at [i*32 +: 32] |
| reqMask | input | LANES | Lane-active mask |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cyclesUsed | output | $clog2(LANES+1) | Passes taken by the current or last operation |
| rValid | output | 1 | Read beat present |
| rBeat | output | $clog2(LANES/16) | Index of the current read beat |
| rData | output | 16*32 | Read data of 16 lanes |

## Verification
Each result is due at a fixed cycle counted from the accepting edge. Cycle 0 is the cycle after that edge. The passes take cycles 0 to P-1. For reads the first beat appears in cycle P and the last in cycle P+3. `done` comes in cycle P for writes and adds, in cycle P+4 for reads, and in cycle 0 for an empty mask. The bench computes P from the lane addresses and mask alone. It then samples on the falling edge of every cycle after acceptance and records the cycle index at which each beat and the done pulse appear. It compares those indices against the computed cycles, as well as checking the data itself against a reference memory kept in the bench.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ADD   = 2'd2
  } scratch_op_e;

  typedef struct packed {
    logic load;
    logic doPass;
  } scratch_ctl_t;
endpackage

// File: rtl/scratch_picker.sv
module scratch_picker #(
  parameter int LANES  = 64,
  parameter int WORD_A = 8,
  parameter int BANK_W = 5
) (
  input  logic [LANES*WORD_A-1:0] laneWord,
  input  logic [LANES-1:0]        pending,
  input  logic                    isAdd,
  output logic [LANES-1:0]        served
);
  localparam int BANKS  = 1 << BANK_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [BANKS-1:0]  found;
  logic [WORD_A-1:0] leadWord [BANKS];
  logic [LANE_W-1:0] leadLane [BANKS];

  // Per bank: the lowest pending lane becomes the leader of this pass.
  always_comb begin
    found = '0;
    for (int b = 0; b < BANKS; b++) begin
      leadWord[b] = '0;
      leadLane[b] = '0;
    end
    for (int i = 0; i < LANES; i++) begin
      if (pending[i] && !found[laneWord[i*WORD_A +: BANK_W]]) begin
        found[laneWord[i*WORD_A +: BANK_W]]    = 1'b1;
        leadWord[laneWord[i*WORD_A +: BANK_W]] = laneWord[i*WORD_A +: WORD_A];
        leadLane[laneWord[i*WORD_A +: BANK_W]] = LANE_W'(i);
      end
    end
  end

  // Reads and writes join the leader on an equal word; adds take the leader only.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (isAdd)
        served[i] = pending[i] && (leadLane[laneWord[i*WORD_A +: BANK_W]] == LANE_W'(i));
      else
        served[i] = pending[i] &&
                    (leadWord[laneWord[i*WORD_A +: BANK_W]] == laneWord[i*WORD_A +: WORD_A]);
    end
  end
endmodule

// File: rtl/scratch_datapath.sv
module scratch_datapath
  import scratch_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int ADDR_W     = 10,
  parameter int PORT_LANES = 16,
  parameter int BEAT_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  scratch_ctl_t                 ctl,
  input  logic [BEAT_W-1:0]            beatSel,
  input  logic [1:0]                   reqOp,
  input  logic [LANES*ADDR_W-1:0]      reqAddr,
  input  logic [LANES*WORD_W-1:0]      reqWdata,
  input  logic [LANES-1:0]             reqMask,
  output logic                         lastPass,
  output logic                         opIsRead,
  output logic                         maskEmpty,
  output logic [PORT_LANES*WORD_W-1:0] rData
);
  localparam int BANK_W = 5;
  localparam int BANKS  = 1 << BANK_W;
  localparam int WORD_A = ADDR_W - 2;
  localparam int ROW_W  = WORD_A - BANK_W;
  localparam int ROWS   = 1 << ROW_W;

  logic [1:0]              opR;
  logic [LANES*WORD_A-1:0] wordR;
  logic [WORD_W-1:0]       dataR   [LANES];
  logic [WORD_W-1:0]       resultR [LANES];
  logic [LANES-1:0]        pending;
  logic [LANES-1:0]        served;
  logic [WORD_W-1:0]       mem     [BANKS][ROWS];

  logic [BANKS-1:0]  bankHit;
  logic [ROW_W-1:0]  bankRow [BANKS];
  logic [WORD_W-1:0] bankVal [BANKS];
  logic              isAdd;
  logic              isWrite;
  logic              unusedAlign;

  assign isAdd     = (opR == OP_ADD);
  assign isWrite   = (opR == OP_WRITE);
  assign opIsRead  = !isAdd && !isWrite;
  assign maskEmpty = (reqMask == '0);
  assign lastPass  = ((pending & ~served) == '0);

  always_comb begin
    unusedAlign = 1'b0;
    for (int i = 0; i < LANES; i++)
      unusedAlign = unusedAlign ^ (^reqAddr[i*ADDR_W +: 2]);
  end

  scratch_picker #(.LANES(LANES), .WORD_A(WORD_A), .BANK_W(BANK_W)) picker (
    .laneWord(wordR),
    .pending (pending),
    .isAdd   (isAdd),
    .served  (served)
  );

  // Request capture and lane bookkeeping.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opR     <= OP_READ;
      wordR   <= '0;
      pending <= '0;
      for (int i = 0; i < LANES; i++) dataR[i] <= '0;
    end else if (ctl.load) begin
      opR     <= reqOp;
      pending <= reqMask;
      for (int i = 0; i < LANES; i++) begin
        wordR[i*WORD_A +: WORD_A] <= reqAddr[i*ADDR_W+2 +: WORD_A];
        dataR[i]                  <= reqWdata[i*WORD_W +: WORD_W];
      end
    end else if (ctl.doPass) begin
      pending <= pending & ~served;
    end
  end

  // One update per bank per pass; the highest served lane wins for writes.
  always_comb begin
    bankHit = '0;
    for (int b = 0; b < BANKS; b++) begin
      bankRow[b] = '0;
      bankVal[b] = '0;
    end
    for (int i = 0; i < LANES; i++) begin
      if (served[i]) begin
        bankHit[wordR[i*WORD_A +: BANK_W]] = 1'b1;
        bankRow[wordR[i*WORD_A +: BANK_W]] = wordR[i*WORD_A+BANK_W +: ROW_W];
        if (isAdd)
          bankVal[wordR[i*WORD_A +: BANK_W]] =
            mem[wordR[i*WORD_A +: BANK_W]][wordR[i*WORD_A+BANK_W +: ROW_W]] + dataR[i];
        else
          bankVal[wordR[i*WORD_A +: BANK_W]] = dataR[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < ROWS; r++)
          mem[b][r] <= '0;
    end else if (ctl.doPass && !opIsRead) begin
      for (int b = 0; b < BANKS; b++)
        if (bankHit[b]) mem[b][bankRow[b]] <= bankVal[b];
    end
  end

  // Read results gather over all passes; inactive lanes stay zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) resultR[i] <= '0;
    end else if (ctl.load) begin
      for (int i = 0; i < LANES; i++) resultR[i] <= '0;
    end else if (ctl.doPass && opIsRead) begin
      for (int i = 0; i < LANES; i++)
        if (served[i])
          resultR[i] <= mem[wordR[i*WORD_A +: BANK_W]][wordR[i*WORD_A+BANK_W +: ROW_W]];
    end
  end

  always_comb begin
    for (int k = 0; k < PORT_LANES; k++)
      rData[k*WORD_W +: WORD_W] = resultR[int'(beatSel)*PORT_LANES + k];
  end

  // R2: every pass makes progress on the pending lanes.
  p_pass_progress_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doPass |-> (served != '0));

  // R5: an add pass never serves more lanes than there are banks.
  p_add_per_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doPass && isAdd) |-> ($countones(served) <= BANKS));

  // R6: only lanes still pending can be served.
  p_served_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doPass |-> ((served & ~pending) == '0));
endmodule

// File: rtl/scratch_control.sv
module scratch_control
  import scratch_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int PORT_LANES = 16,
  parameter int BEAT_W     = 2,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              maskEmpty,
  input  logic              lastPass,
  input  logic              opIsRead,
  output scratch_ctl_t      ctl,
  output logic [BEAT_W-1:0] beatCnt,
  output logic              busy,
  output logic              done,
  output logic              rValid,
  output logic [CNT_W-1:0]  cyclesUsed
);
  localparam int BEATS = LANES / PORT_LANES;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RET, S_FIN} state_e;
  state_e state, stateNext;

  logic lastBeat;
  assign lastBeat   = (beatCnt == BEAT_W'(BEATS - 1));
  assign ctl.load   = (state == S_IDLE) && reqValid;
  assign ctl.doPass = (state == S_RUN);
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign rValid     = (state == S_RET);

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE: if (reqValid) stateNext = maskEmpty ? S_FIN : S_RUN;
      S_RUN:  if (lastPass) stateNext = opIsRead ? S_RET : S_FIN;
      S_RET:  if (lastBeat) stateNext = S_FIN;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      beatCnt    <= '0;
      cyclesUsed <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load)        cyclesUsed <= '0;
      else if (ctl.doPass) cyclesUsed <= cyclesUsed + CNT_W'(1);
      if (state == S_RET)  beatCnt <= beatCnt + BEAT_W'(1);
      else                 beatCnt <= '0;
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rValid && !lastBeat) |=> (rValid && beatCnt == $past(beatCnt) + BEAT_W'(1)));

  p_pass_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyclesUsed <= CNT_W'(LANES));
endmodule

// File: rtl/banked_scratch.sv
module banked_scratch
  import scratch_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int ADDR_W     = 10,
  parameter int PORT_LANES = 16,
  localparam int BEATS     = LANES / PORT_LANES,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  input  logic [1:0]                   reqOp,
  input  logic [LANES*ADDR_W-1:0]      reqAddr,
  input  logic [LANES*WORD_W-1:0]      reqWdata,
  input  logic [LANES-1:0]             reqMask,
  output logic                         busy,
  output logic                         done,
  output logic [CNT_W-1:0]             cyclesUsed,
  output logic                         rValid,
  output logic [BEAT_W-1:0]            rBeat,
  output logic [PORT_LANES*WORD_W-1:0] rData
);
  scratch_ctl_t ctl;
  logic lastPass, opIsRead, maskEmpty;

  scratch_control #(.LANES(LANES), .PORT_LANES(PORT_LANES), .BEAT_W(BEAT_W), .CNT_W(CNT_W)) control (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .maskEmpty(maskEmpty),
    .lastPass(lastPass), .opIsRead(opIsRead), .ctl(ctl), .beatCnt(rBeat),
    .busy(busy), .done(done), .rValid(rValid), .cyclesUsed(cyclesUsed)
  );

  scratch_datapath #(.LANES(LANES), .ADDR_W(ADDR_W), .PORT_LANES(PORT_LANES), .BEAT_W(BEAT_W)) datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .beatSel(rBeat), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .lastPass(lastPass), .opIsRead(opIsRead), .maskEmpty(maskEmpty), .rData(rData)
  );
endmodule

// File: tb/tb_banked_scratch.sv
`timescale 1ns/1ps
module tb_banked_scratch;
  localparam int LANES = 64, ADDR_W = 10, PORT = 16, BEATS = 4, WORDS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                    reqValid = 1'b0;
  logic [1:0]              reqOp = 2'd0;
  logic [LANES*ADDR_W-1:0] reqAddr = '0;
  logic [LANES*32-1:0]     reqWdata = '0;
  logic [LANES-1:0]        reqMask = '0;
  logic                    busy, done, rValid;
  logic [6:0]              cyclesUsed;
  logic [1:0]              rBeat;
  logic [PORT*32-1:0]      rData;

  banked_scratch dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .busy(busy), .done(done),
    .cyclesUsed(cyclesUsed), .rValid(rValid), .rBeat(rBeat), .rData(rData)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] model [WORDS];
  int          laneA [LANES];
  logic [31:0] laneD [LANES];
  logic [LANES-1:0] laneM;
  logic [31:0] got [LANES];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expPasses(int op);
    int worst = 0;
    for (int b = 0; b < 32; b++) begin
      int n = 0;
      for (int i = 0; i < LANES; i++) begin
        if (laneM[i] && ((laneA[i] >> 2) % 32) == b) begin
          bit fresh = 1;
          if (op != 2)
            for (int j = 0; j < i; j++)
              if (laneM[j] && (laneA[j] >> 2) == (laneA[i] >> 2)) fresh = 0;
          if (fresh) n++;
        end
      end
      if (n > worst) worst = n;
    end
    return worst;
  endfunction

  task automatic runOp(int op, bit hold, string req);
    int P, c, beats, firstBeat, doneAt;
    bit busyOk, beatOk;
    logic [31:0] expD [LANES];
    P = expPasses(op);
    for (int i = 0; i < LANES; i++) begin
      expD[i] = laneM[i] ? model[laneA[i] >> 2] : 32'd0;
      reqAddr[i*ADDR_W +: ADDR_W] = ADDR_W'(laneA[i]);
      reqWdata[i*32 +: 32] = laneD[i];
      got[i] = 32'hdeadbeef;
    end
    reqMask = laneM; reqOp = 2'(op); reqValid = 1'b1;
    @(negedge clk);
    if (hold) reqWdata = ~reqWdata; else reqValid = 1'b0;
    c = 0; beats = 0; firstBeat = -1; doneAt = -1; busyOk = 1; beatOk = 1;
    while (c < 400) begin
      if (!busy) busyOk = 0;
      if (rValid) begin
        if (firstBeat < 0) firstBeat = c;
        if (int'(rBeat) != beats || beats >= BEATS) beatOk = 0;
        else for (int k = 0; k < PORT; k++) got[beats*PORT + k] = rData[k*32 +: 32];
        beats++;
      end
      if (done) begin doneAt = c; break; end
      c++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    if (op == 0 && P > 0)
      check(doneAt == P + BEATS, "R8", {req, " read done cycle"}, doneAt, P + BEATS);
    else
      check(doneAt == P, (P == 0) ? "R10" : "R8", {req, " done cycle"}, doneAt, P);
    check(int'(cyclesUsed) == P, (op == 2) ? "R5" : "R2", {req, " pass count"}, cyclesUsed, P);
    if (hold) check(busyOk, "R9", {req, " busy held"}, busyOk, 1);
    if (op == 0) begin
      int expBeats = (P > 0) ? BEATS : 0;
      check(beats == expBeats && beatOk, "R7", {req, " beat count"}, beats, expBeats);
      if (P > 0) begin
        int bad = -1;
        check(firstBeat == P, "R7", {req, " first beat cycle"}, firstBeat, P);
        for (int i = 0; i < LANES; i++) if (bad < 0 && got[i] !== expD[i]) bad = i;
        if (bad < 0) check(1, req, "data", 0, 0);
        else check(0, req, $sformatf("%s data lane %0d", req, bad), got[bad], expD[bad]);
      end
    end
    @(negedge clk);
    check(!done && !busy, "R8", {req, " done single, idle after"}, {done, busy}, 0);
    for (int i = 0; i < LANES; i++)
      if (laneM[i]) begin
        if (op == 1) model[laneA[i] >> 2] = laneD[i];
        else if (op == 2) model[laneA[i] >> 2] = model[laneA[i] >> 2] + laneD[i];
      end
  endtask

  task automatic setStride(int base, int stride);
    for (int i = 0; i < LANES; i++) begin
      laneA[i] = ((base + i * stride) * 4) % 1024;
      laneD[i] = $urandom;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < WORDS; w++) model[w] = 32'd0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rValid, "R9", "reset outputs", {busy, done, rValid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    laneM = '1;
    setStride(0, 1); runOp(0, 0, "R1 zero after reset");
    setStride(0, 1); runOp(1, 0, "R1 stride write");
    runOp(0, 0, "R1 stride readback");

    for (int s = 1; s <= 40; s++) begin
      setStride(s * 3, s); runOp(1, 0, "R2 sweep write");
      runOp(0, 0, "R2 sweep read");
    end

    for (int i = 0; i < LANES; i++) laneA[i] = 12; runOp(0, 0, "R3 all same word");
    for (int i = 0; i < LANES; i++) laneA[i] = (i % 8) * 132; runOp(0, 0, "R3 eight groups");

    for (int i = 0; i < LANES; i++) begin laneA[i] = 64; laneD[i] = 100 + i; end
    runOp(1, 0, "R4 same word write");
    runOp(0, 0, "R4 readback");
    check(model[16] == 163, "R4", "model last lane", model[16], 163);

    for (int i = 0; i < LANES; i++) begin laneA[i] = 200; laneD[i] = i + 1; end
    runOp(2, 0, "R5 add one word");
    runOp(0, 0, "R5 readback");
    laneM = 64'h0000_0000_ffff_ffff;
    setStride(0, 1); runOp(2, 0, "R5 add spread");
    laneM = '1;
    for (int i = 0; i < LANES; i++) begin laneA[i] = (i % 4) * 128 + 4 * (i % 3); laneD[i] = $urandom; end
    runOp(2, 0, "R5 add mixed");
    runOp(0, 0, "R5 mixed readback");

    for (int t = 0; t < 6; t++) begin
      laneM = {$urandom, $urandom};
      setStride(t, 2); runOp(1, 0, "R6 masked write");
      laneM = '1; runOp(0, 0, "R6 full readback");
      laneM = {$urandom, $urandom}; runOp(0, 0, "R6 masked read");
    end

    laneM = '0; setStride(5, 1); runOp(1, 0, "R10 empty write");
    runOp(0, 0, "R10 empty read");
    laneM = '1; runOp(0, 0, "R10 untouched readback");

    setStride(9, 5); runOp(1, 1, "R9 held request");
    runOp(0, 0, "R9 readback");

    for (int t = 0; t < 120; t++) begin
      laneM = {$urandom, $urandom};
      for (int i = 0; i < LANES; i++) begin
        laneA[i] = 4 * $urandom_range(0, 255) + $urandom_range(0, 3);
        if (t % 2 == 0) laneA[i] = laneA[i] % 128 + 4 * 32 * $urandom_range(0, 2);
        laneD[i] = $urandom;
      end
      runOp(t % 3, 0, (t % 3 == 2) ? "R5 random" : "R2 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule